// File: doc/BRIEF.md
# Round-Robin Process Swap Queue

This block keeps a first-in first-out list of processes that are ready to run. It also swaps the running process for the next ready one. A process is described by just two pointers: where its code resumes (instruction pointer) and where its local frame lives in memory (workspace pointer). The evaluation stack is not saved on a swap. Software arranges that the stack holds nothing worth keeping when a process gives up the processor. Saving the context therefore means storing two words.

When the running process gives up the processor, the block appends that process's pointer pair to the back of the ready list. It then takes the pair at the front of the list and makes it the running process. The swap takes a fixed two cycles:
- First cycle: the outgoing pair is written to the back of the list.
- Second cycle: the front pair is removed and loaded into the current-pointer registers.

Newly ready processes enter through a separate enqueue port. Status outputs report:
- the list depth,
- whether the list is empty or full,
- whether a swap is in progress,
- one-cycle pulses for a refused swap and for a dropped enqueue.

Top module: `proc_swap_queue`

## Requirements
- R1: While reset is low, the current instruction and workspace pointers take the values on `resetIp`/`resetWp`. After reset, `queueCount` is 0, `queueEmpty` is 1, and `busy`, `queueFull`, `noSwitch` and `overflow` are 0.
- R2: A `deschedReq` sampled while `busy` is 0, with `queueCount` nonzero, starts a swap. After that edge, `busy` is 1 for exactly one cycle and `queueCount` is one higher (plus one more if an enqueue was accepted in the same cycle). After the second edge, `curIp`/`curWp` hold the pair that was at the front of the list and `busy` is 0.
- R3: The outgoing pair goes to the back of the list. Repeated swaps therefore visit the ready processes in round-robin order, and the original process returns after `queueCount` further swaps.
- R4: A `deschedReq` sampled while `busy` is 0 and `queueCount` is 0 leaves the current pointers unchanged and keeps `busy` at 0. `noSwitch` is 1 for exactly the one cycle after that edge. An enqueue in the same cycle is still accepted.
- R5: If `enqValid` is high in the same cycle a swap starts, the enqueued pair is placed directly behind the outgoing pair.
- R6: An enqueue sampled while `queueCount` is at least `DEPTH` is discarded and leaves `queueCount` unaffected by it. `overflow` is 1 for exactly the one cycle after that edge.
- R7: A `deschedReq` sampled while `busy` is 1 is ignored. It neither starts a second swap nor raises `noSwitch`.
- R8: Accepted enqueues come out in arrival order. `queueEmpty` is 1 exactly when `queueCount` is 0. `queueFull` is 1 exactly when `queueCount` is at least `DEPTH`. While `busy` is 0, `queueCount` never exceeds `DEPTH`.
- R9: A swap started with the list full (`queueCount` = `DEPTH`) completes normally, using one spare slot for the outgoing pair during the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| resetIp | input | PTR_W | Instruction pointer loaded while in reset |
| resetWp | input | PTR_W | Workspace pointer loaded while in reset |
| deschedReq | input | 1 | Running process gives up the processor |
| enqValid | input | 1 | Add a newly ready process to the list |
| enqIp | input | PTR_W | Instruction pointer of the process being added |
| enqWp | input | PTR_W | Workspace pointer of the process being added |
| curIp | output | PTR_W | Instruction pointer of the running process |
| curWp | output | PTR_W | Workspace pointer of the running process |
| busy | output | 1 | Second cycle of a swap is in progress |
| noSwitch | output | 1 | One-cycle pulse: swap refused because the list was empty |
| overflow | output | 1 | One-cycle pulse: enqueue dropped because the list was full |
| queueCount | output | $clog2(DEPTH+2) | Number of pairs held in the list |
| queueEmpty | output | 1 | List holds no pairs |
| queueFull | output | 1 | List holds DEPTH or more pairs |

## Verification
The bench fills the list to every depth from one to `DEPTH` and then runs one more swap than there are entries. A design that pops before it pushes, or that loses the tail pointer on wrap, would return the processes in the wrong order or never bring back the original one.

It drives an enqueue in the same cycle as a swap start. A design that orders the two writes the wrong way round would run the new process before the one just set aside.

It pushes past capacity, including while a swap holds the spare slot. A design that counts the spare slot as free capacity would accept an extra entry, and one without the spare slot would corrupt a full-list swap.

It also issues deschedule requests during the busy cycle and on an empty list. A design that lets these through would swap twice or change the pointers when it should only pulse `noSwitch`.

// File: rtl/proc_swap_pkg.sv
package proc_swap_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } swap_state_t;

  typedef struct packed {
    logic saveCur;     // write outgoing pair at tail
    logic pushExt;     // write external pair (behind saved one if both)
    logic popLoad;     // take head pair into current registers
  } swap_strobe_t;

endpackage

// File: rtl/proc_swap_ctrl.sv
module proc_swap_ctrl
  import proc_swap_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             deschedReq,
  input  logic             enqValid,
  input  logic [CNT_W-1:0] queueCount,
  output swap_strobe_t     strobe,
  output logic             busy,
  output logic             noSwitch,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] DepthC = CNT_W'(DEPTH);

  swap_state_t state, stateNext;
  logic accept;
  logic haveWork;
  logic roomForExt;

  assign accept     = (state == ST_IDLE) && deschedReq;
  assign haveWork   = (queueCount != '0);
  assign roomForExt = (queueCount < DepthC);

  always_comb begin
    strobe.saveCur = accept && haveWork;
    strobe.pushExt = enqValid && roomForExt;
    strobe.popLoad = (state == ST_LOAD);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept && haveWork) stateNext = ST_LOAD;
      ST_LOAD: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      noSwitch <= 1'b0;
      overflow <= 1'b0;
    end else begin
      state    <= stateNext;
      noSwitch <= accept && !haveWork;
      overflow <= enqValid && !roomForExt;
    end
  end

  assign busy = (state == ST_LOAD);

endmodule

// File: rtl/proc_swap_datapath.sv
module proc_swap_datapath
  import proc_swap_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int DEPTH = 8,
  localparam int SLOTS = DEPTH + 1,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  swap_strobe_t     strobe,
  input  logic [PTR_W-1:0] resetIp,
  input  logic [PTR_W-1:0] resetWp,
  input  logic [PTR_W-1:0] enqIp,
  input  logic [PTR_W-1:0] enqWp,
  output logic [PTR_W-1:0] curIp,
  output logic [PTR_W-1:0] curWp,
  output logic [CNT_W-1:0] queueCount
);

  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(SLOTS - 1);

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] idx);
    return (idx == LastIdx) ? '0 : idx + 1'b1;
  endfunction

  logic [PTR_W-1:0] slotIp [SLOTS];
  logic [PTR_W-1:0] slotWp [SLOTS];
  logic [IDX_W-1:0] headIdx, tailIdx, extIdx, tailNext;

  // external pair lands one slot further on when the outgoing pair is saved too
  assign extIdx = strobe.saveCur ? stepIdx(tailIdx) : tailIdx;

  always_comb begin
    tailNext = tailIdx;
    if (strobe.saveCur && strobe.pushExt) tailNext = stepIdx(stepIdx(tailIdx));
    else if (strobe.saveCur || strobe.pushExt) tailNext = stepIdx(tailIdx);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    localparam logic [IDX_W-1:0] MyIdx = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotIp[g] <= '0;
        slotWp[g] <= '0;
      end else if (strobe.saveCur && tailIdx == MyIdx) begin
        slotIp[g] <= curIp;
        slotWp[g] <= curWp;
      end else if (strobe.pushExt && extIdx == MyIdx) begin
        slotIp[g] <= enqIp;
        slotWp[g] <= enqWp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx    <= '0;
      tailIdx    <= '0;
      queueCount <= '0;
      curIp      <= resetIp;
      curWp      <= resetWp;
    end else begin
      tailIdx    <= tailNext;
      queueCount <= queueCount + CNT_W'(strobe.saveCur) + CNT_W'(strobe.pushExt)
                    - CNT_W'(strobe.popLoad);
      if (strobe.popLoad) begin
        curIp   <= slotIp[headIdx];
        curWp   <= slotWp[headIdx];
        headIdx <= stepIdx(headIdx);
      end
    end
  end

endmodule

// File: rtl/proc_swap_queue.sv
module proc_swap_queue
  import proc_swap_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PTR_W-1:0] resetIp,
  input  logic [PTR_W-1:0] resetWp,
  input  logic             deschedReq,
  input  logic             enqValid,
  input  logic [PTR_W-1:0] enqIp,
  input  logic [PTR_W-1:0] enqWp,
  output logic [PTR_W-1:0] curIp,
  output logic [PTR_W-1:0] curWp,
  output logic             busy,
  output logic             noSwitch,
  output logic             overflow,
  output logic [CNT_W-1:0] queueCount,
  output logic             queueEmpty,
  output logic             queueFull
);

  localparam logic [CNT_W-1:0] DepthC = CNT_W'(DEPTH);

  swap_strobe_t strobe;

  proc_swap_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .deschedReq (deschedReq),
    .enqValid   (enqValid),
    .queueCount (queueCount),
    .strobe     (strobe),
    .busy       (busy),
    .noSwitch   (noSwitch),
    .overflow   (overflow)
  );

  proc_swap_datapath #(.PTR_W(PTR_W), .DEPTH(DEPTH)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .resetIp    (resetIp),
    .resetWp    (resetWp),
    .enqIp      (enqIp),
    .enqWp      (enqWp),
    .curIp      (curIp),
    .curWp      (curWp),
    .queueCount (queueCount)
  );

  assign queueEmpty = (queueCount == '0);
  assign queueFull  = (queueCount >= DepthC);

endmodule

// File: rtl/proc_swap_queue_chk.sv
module proc_swap_queue_chk #(
  parameter int PTR_W = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 2)
) (
  input logic             clk,
  input logic             rstN,
  input logic             deschedReq,
  input logic [PTR_W-1:0] curIp,
  input logic [PTR_W-1:0] curWp,
  input logic             busy,
  input logic             noSwitch,
  input logic             overflow,
  input logic [CNT_W-1:0] queueCount
);

  localparam logic [CNT_W-1:0] DepthC = CNT_W'(DEPTH);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (queueCount == '0) && !busy && !noSwitch && !overflow);

  assert_swap_two_cycles_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  assert_saved_pair_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (queueCount != '0));

  assert_pointers_move_only_on_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> ($stable(curIp) && $stable(curWp)));

  assert_hold_on_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    noSwitch |-> (!busy && $past(queueCount) == '0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> ($past(queueCount) >= DepthC));

  assert_busy_request_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && deschedReq) |=> (!busy && !noSwitch));

  assert_capacity_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (queueCount <= DepthC));

endmodule

bind proc_swap_queue proc_swap_queue_chk #(.PTR_W(PTR_W), .DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .deschedReq (deschedReq),
  .curIp      (curIp),
  .curWp      (curWp),
  .busy       (busy),
  .noSwitch   (noSwitch),
  .overflow   (overflow),
  .queueCount (queueCount)
);

// File: tb/proc_swap_queue_tb.sv
module proc_swap_queue_tb_top;

  localparam int PTR_W = 16;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PTR_W-1:0] resetIp = '0, resetWp = '0;
  logic deschedReq = 1'b0, enqValid = 1'b0;
  logic [PTR_W-1:0] enqIp = '0, enqWp = '0;
  logic [PTR_W-1:0] curIp, curWp;
  logic busy, noSwitch, overflow, queueEmpty, queueFull;
  logic [CNT_W-1:0] queueCount;

  always #4 clk = ~clk;  // 125 MHz

  proc_swap_queue #(.PTR_W(PTR_W), .DEPTH(DEPTH)) dut_i (.*);

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // requirement-level model
  logic [PTR_W-1:0] mIp[$];
  logic [PTR_W-1:0] mWp[$];
  logic [PTR_W-1:0] mCurIp, mCurWp;
  bit mBusy;

  task automatic compare(input string tag, input bit expNs, input bit expOv);
    int n = mIp.size();
    total++;
    if (curIp !== mCurIp || curWp !== mCurWp || queueCount !== CNT_W'(n) ||
        busy !== mBusy || noSwitch !== expNs || overflow !== expOv ||
        queueEmpty !== (n == 0) || queueFull !== (n >= DEPTH)) begin
      bad++;
      $display("FAIL %s: got ip=%h wp=%h cnt=%0d busy=%b ns=%b ov=%b emp=%b full=%b exp ip=%h wp=%h cnt=%0d busy=%b ns=%b ov=%b",
               tag, curIp, curWp, queueCount, busy, noSwitch, overflow, queueEmpty, queueFull,
               mCurIp, mCurWp, n, mBusy, expNs, expOv);
    end
  endtask

  task automatic doReset(input logic [PTR_W-1:0] rip, input logic [PTR_W-1:0] rwp);
    @(negedge clk);
    rstN = 1'b0; deschedReq = 1'b0; enqValid = 1'b0;
    resetIp = rip; resetWp = rwp;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mIp.delete(); mWp.delete();
    mCurIp = rip; mCurWp = rwp; mBusy = 1'b0;
    compare("R1 reset state", 1'b0, 1'b0);
  endtask

  task automatic step(input bit d, input bit e, input logic [PTR_W-1:0] ei,
                      input logic [PTR_W-1:0] ew, input string tag);
    int n;
    bit expNs, expOv, okExt, nb;
    @(negedge clk);
    deschedReq = d; enqValid = e; enqIp = ei; enqWp = ew;
    n = mIp.size();
    expNs = 1'b0; nb = 1'b0;
    okExt = e && (n < DEPTH);
    expOv = e && !okExt;
    if (mBusy) begin
      mCurIp = mIp.pop_front();
      mCurWp = mWp.pop_front();
    end else if (d) begin
      if (n > 0) begin
        mIp.push_back(mCurIp); mWp.push_back(mCurWp); nb = 1'b1;
      end else expNs = 1'b1;
    end
    if (okExt) begin
      mIp.push_back(ei); mWp.push_back(ew);
    end
    mBusy = nb;
    @(posedge clk);
    #2;
    compare(tag, expNs, expOv);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, '0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset(16'h0100, 16'h0200);
    idle("R1 idle after reset");

    // R4: deschedule on empty list
    step(1'b1, 1'b0, '0, '0, "R4 empty deschedule");
    idle("R4 pulse ends");
    step(1'b1, 1'b1, 16'h0AAA, 16'h0BBB, "R4 empty deschedule with enqueue");
    idle("R4 enqueue kept");

    // R2/R3/R8: fill to every depth, then rotate one more time than entries
    for (int n = 1; n <= DEPTH; n++) begin
      doReset(16'h7000 + PTR_W'(n), 16'h8000 + PTR_W'(n));
      for (int i = 0; i < n; i++)
        step(1'b0, 1'b1, 16'h1000 + PTR_W'(n * 16 + i), 16'h2000 + PTR_W'(n * 16 + i),
             "R8 enqueue fill");
      for (int k = 0; k <= n; k++) begin
        step(1'b1, 1'b0, '0, '0, "R2 swap save cycle");
        step(1'b0, 1'b0, '0, '0, "R3 swap load round-robin");
      end
    end

    // R5: enqueue in the same cycle as swap start
    doReset(16'h0111, 16'h0222);
    step(1'b0, 1'b1, 16'h3001, 16'h4001, "R8 enqueue");
    step(1'b0, 1'b1, 16'h3002, 16'h4002, "R8 enqueue");
    step(1'b1, 1'b1, 16'h3003, 16'h4003, "R5 swap with enqueue");
    idle("R5 load");
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, '0, '0, "R5 order save");
      idle("R5 order load");
    end

    // R6/R9: overflow and full-list swap
    doReset(16'h0333, 16'h0444);
    for (int i = 0; i < DEPTH + 2; i++)
      step(1'b0, 1'b1, 16'h5000 + PTR_W'(i), 16'h6000 + PTR_W'(i), "R6 fill past capacity");
    idle("R6 pulse ends");
    step(1'b1, 1'b1, 16'h5F00, 16'h6F00, "R9 full swap with dropped enqueue");
    step(1'b0, 1'b1, 16'h5F01, 16'h6F01, "R6 enqueue during spare-slot use");
    for (int k = 0; k < DEPTH + 1; k++) begin
      step(1'b1, 1'b0, '0, '0, "R9 full rotation save");
      idle("R9 full rotation load");
    end

    // R7: deschedule while busy
    doReset(16'h0555, 16'h0666);
    step(1'b0, 1'b1, 16'h9001, 16'h9101, "R8 enqueue");
    step(1'b0, 1'b1, 16'h9002, 16'h9102, "R8 enqueue");
    step(1'b1, 1'b0, '0, '0, "R2 swap save");
    step(1'b1, 1'b0, '0, '0, "R7 deschedule while busy");
    idle("R7 no second swap");
    step(1'b1, 1'b0, '0, '0, "R2 swap save");
    step(1'b1, 1'b1, 16'h9003, 16'h9103, "R7 busy deschedule with enqueue");
    idle("R7 after");
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, '0, '0, "R3 rotate save");
      idle("R3 rotate load");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule